// File: doc/BRIEF.md
# ADC Sample Streaming Fabric Node

This block is an endpoint on a switch fabric, placed in front of a multi-channel sampling front end. It acts as both a sink and a source. As a sink, it takes a byte-serial control word from the fabric. As a source, it streams the front end's samples back out to a chosen destination node.

A start command does four things:
- latches the destination address and the channel enable mask;
- clears the per-channel timestamps;
- discards anything still queued;
- sends one addressing word ahead of the sample words.

Every sample word carries a rolling 8-bit timestamp for its own channel. A receiver that sees a gap larger than one between two words of the same channel knows that samples were lost.

A disconnect command stops the stream and sends a one-cycle done pulse back toward the fabric. Samples that arrive while the transmit port is stalled wait in a small queue. Samples that arrive when the queue is full are dropped.

Top module: `adc_stream_node`

## Requirements
- R1: The control word is built from four accepted receive bytes, least significant byte first. It takes effect on the clock edge after the fourth byte.
- R2: A control word with bit 31 set and bit 30 clear does all of the following: starts the stream, latches the destination from bits 23:16, latches the enable mask from bits 7:0 (bit X enables channel X), resets every channel timestamp to 0, and empties the queue.
- R3: A control word with bit 30 set disconnects the node, whatever the value of bit 31. It raises done_o for exactly one cycle, stops transmission and empties the queue.
- R4: Before a start, and after a disconnect, tx_valid_o stays low and incoming samples are ignored. A control word with both bit 31 and bit 30 clear has no effect.
- R5: The first word transmitted after a start is {24'b0, destination}.
- R6: Each later word is laid out as follows: timestamp in bits 31:24, a one-hot channel tag with bit 16+X set for channel X in bits 23:16, zero in bits 15:14, and the sample in bits 13:0.
- R7: Each channel has its own timestamp. It increments by one for each accepted sample of that channel and wraps modulo 256.
- R8: A sample from a channel whose enable bit is clear is dropped and does not advance that channel's timestamp.
- R9: While the transmit port is stalled, up to FIFO_DEPTH samples are queued in arrival order. A sample that arrives when the queue is full is dropped, but its channel's timestamp still advances.
- R10: While tx_valid_o is high and tx_ready_i is low, tx_data_o holds its value.
- R11: After reset, tx_valid_o and done_o are low, and any partially received control word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Control byte valid |
| rx_byte_i | input | 8 | Control byte from the fabric |
| tx_valid_o | output | 1 | Transmit word valid |
| tx_ready_i | input | 1 | Fabric accepts the transmit word |
| tx_data_o | output | 32 | Transmit word |
| done_o | output | 1 | One-cycle pulse on disconnect |
| smp_valid_i | input | 1 | New sample present |
| smp_chan_i | input | $clog2(NUM_CH) | Channel index of the sample |
| smp_data_i | input | 14 | Sample value |

## Verification
The bench builds the block with its defaults: eight channels and a four-entry queue. With these values it can sweep every channel tag across several rounds and push the queue past full with only a few samples. It also drives a single channel through more than 256 samples, which checks the timestamp wrap arithmetically against a per-channel model kept in the bench. Restarting with sparse masks, sending a disconnect word that also carries the start bit, sending inert words, and resetting mid-word cover the remaining control paths.

// File: rtl/adc_node_pkg.sv
package adc_node_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned SMP_W   = 14;
  localparam int unsigned TS_W    = 8;
  localparam int unsigned TAG_W   = 8;
  localparam int unsigned GO_BIT  = 31;
  localparam int unsigned END_BIT = 30;

  typedef struct packed {
    logic [TS_W-1:0]  ts;
    logic [TAG_W-1:0] tag;
    logic [1:0]       pad;
    logic [SMP_W-1:0] smp;
  } smp_word_t;
endpackage

// File: rtl/adc_cfg_rx.sv
module adc_cfg_rx (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  output logic        word_valid_o,
  output logic [31:0] word_o
);
  logic [1:0]  idx_q;
  logic [23:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q        <= '0;
      low_q        <= '0;
      word_valid_o <= 1'b0;
      word_o       <= '0;
    end else begin
      word_valid_o <= 1'b0;
      if (byte_valid_i) begin
        if (idx_q == 2'd3) begin
          word_o       <= {byte_i, low_q};
          word_valid_o <= 1'b1;
          idx_q        <= '0;
        end else begin
          low_q[{idx_q, 3'b000} +: 8] <= byte_i;
          idx_q <= idx_q + 2'd1;
        end
      end
    end
  end

  assert_word_after_byte_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(byte_valid_i));
endmodule

// File: rtl/adc_ts_bank.sv
module adc_ts_bank #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned TS_W   = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            inc_i,
  input  logic [CH_W-1:0] ch_i,
  output logic [TS_W-1:0] ts_o
);
  logic [TS_W-1:0] ts_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           ts_q[g] <= '0;
      else if (clr_i)                        ts_q[g] <= '0;
      else if (inc_i && ch_i == CH_W'(g))    ts_q[g] <= ts_q[g] + 1'b1;
    end
  end

  assign ts_o = ts_q[ch_i];

  assert_ts_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && ch_i == $past(ch_i) && $past(inc_i && !clr_i)) |-> ts_o == $past(ts_o) + 1'b1);
endmodule

// File: rtl/adc_smp_fifo.sv
module adc_smp_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          full, wr, rd;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign wr      = push_i && !full;
  assign rd      = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr) wr_q <= nxt(wr_q);
      if (rd) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(wr) - CW'(rd);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (wr && !flush_i && wr_q == AW'(g))    mem_q[g] <= data_i;
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_full_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !pop_i && !flush_i) |=> full);
endmodule

// File: rtl/adc_stream_node.sv
module adc_stream_node
  import adc_node_pkg::*;
#(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [31:0]      tx_data_o,
  output logic             done_o,
  input  logic             smp_valid_i,
  input  logic [CH_W-1:0]  smp_chan_i,
  input  logic [SMP_W-1:0] smp_data_i
);
  logic              cmd_v;
  logic [31:0]       cmd;
  logic              go, stop, accept, fire, pop, empty;
  logic              active_q, hdr_q;
  logic [7:0]        dest_q;
  logic [NUM_CH-1:0] mask_q;
  logic [TS_W-1:0]   ts;
  smp_word_t         smp_w;
  logic [31:0]       head;

  adc_cfg_rx u_cfg (
    .clk_i, .rst_ni,
    .byte_valid_i (rx_valid_i),
    .byte_i       (rx_byte_i),
    .word_valid_o (cmd_v),
    .word_o       (cmd)
  );

  assign stop   = cmd_v && cmd[END_BIT];
  assign go     = cmd_v && cmd[GO_BIT] && !cmd[END_BIT];
  assign accept = smp_valid_i && active_q && mask_q[smp_chan_i] && !go && !stop;

  adc_ts_bank #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_ts (
    .clk_i, .rst_ni,
    .clr_i (go),
    .inc_i (accept),
    .ch_i  (smp_chan_i),
    .ts_o  (ts)
  );

  always_comb begin
    smp_w     = '0;
    smp_w.ts  = ts;
    smp_w.tag = TAG_W'(1) << smp_chan_i;
    smp_w.smp = smp_data_i;
  end

  adc_smp_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_q (
    .clk_i, .rst_ni,
    .flush_i (go || stop),
    .push_i  (accept),
    .data_i  (smp_w),
    .pop_i   (pop),
    .data_o  (head),
    .empty_o (empty)
  );

  assign tx_valid_o = active_q && (hdr_q || !empty);
  assign tx_data_o  = hdr_q ? {24'b0, dest_q} : head;
  assign fire       = tx_valid_o && tx_ready_i;
  assign pop        = fire && !hdr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hdr_q    <= 1'b0;
      dest_q   <= '0;
      mask_q   <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= stop;
      if (stop) begin
        active_q <= 1'b0;
        hdr_q    <= 1'b0;
      end else if (go) begin
        active_q <= 1'b1;
        hdr_q    <= 1'b1;
        dest_q   <= cmd[23:16];
        mask_q   <= cmd[NUM_CH-1:0];
      end else if (fire && hdr_q) begin
        hdr_q <= 1'b0;
      end
    end
  end

  assert_done_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !tx_valid_o);
  assert_idle_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !tx_valid_o);
  assert_header_form_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && hdr_q) |-> tx_data_o[31:8] == 24'b0);
  assert_sample_form_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !hdr_q) |-> ($onehot(tx_data_o[23:16]) && tx_data_o[15:14] == 2'b00));
  assert_hold_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !cmd_v) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

// File: tb/tb_adc_stream_node.sv
module tb_adc_stream_node;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_valid, done;
  logic        tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic        smp_valid = 1'b0;
  logic [2:0]  smp_chan = '0;
  logic [13:0] smp_data = '0;

  int n_chk = 0, n_fail = 0;
  int ts_m [8];

  always #2.5 clk = ~clk;

  adc_stream_node dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .done_o(done),
    .smp_valid_i(smp_valid), .smp_chan_i(smp_chan), .smp_data_i(smp_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // ends one cycle after the word takes effect
  task automatic send_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) send_byte(w[i*8 +: 8]);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic send_smp(input int ch, input logic [13:0] d);
    smp_valid = 1'b1; smp_chan = 3'(ch); smp_data = d;
    @(posedge clk); @(negedge clk);
    smp_valid = 1'b0;
  endtask

  function automatic logic [31:0] exp_word(input int ch, input int ts, input logic [13:0] d);
    return {8'(ts), 8'(1 << ch), 2'b00, d};
  endfunction

  task automatic pop_expect(input string req, input logic [31:0] exp);
    chk({req, " valid"}, {31'b0, tx_valid}, 32'd1);
    chk(req, tx_data, exp);
    tx_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic start(input logic [7:0] dst, input logic [7:0] mask);
    send_word({8'h80, dst, 8'h00, mask});
    for (int c = 0; c < 8; c++) ts_m[c] = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 tx_valid reset", {31'b0, tx_valid}, 0);
    chk("R11 done reset", {31'b0, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 samples before start ignored
    send_smp(3, 14'h123);
    @(negedge clk);
    chk("R4 no output before start", {31'b0, tx_valid}, 0);

    // R1/R2/R5 start, header, LSB-first assembly
    start(8'h5A, 8'hFF);
    pop_expect("R5 header", 32'h0000_005A);
    chk("R5 header consumed", {31'b0, tx_valid}, 0);

    // R6/R7 sweep all channels over rounds
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 8; c++) begin
        logic [13:0] d = 14'(c * 1500 + r * 77 + 5);
        send_smp(c, d);
        pop_expect("R6 R7 sweep", exp_word(c, ts_m[c], d));
        ts_m[c]++;
      end

    // R10 stall holds data
    send_smp(4, 14'h2AAA);
    chk("R10 held data", tx_data, exp_word(4, ts_m[4], 14'h2AAA));
    repeat (3) @(negedge clk);
    chk("R10 held data later", tx_data, exp_word(4, ts_m[4], 14'h2AAA));
    pop_expect("R10 release", exp_word(4, ts_m[4], 14'h2AAA));
    ts_m[4]++;

    // R2/R8 restart, sparse mask, ts cleared
    start(8'h11, 8'h05);
    pop_expect("R2 new header", 32'h0000_0011);
    send_smp(0, 14'h0001);
    pop_expect("R2 ts cleared", exp_word(0, ts_m[0], 14'h0001)); ts_m[0]++;
    send_smp(1, 14'h0002);
    @(negedge clk);
    chk("R8 disabled dropped", {31'b0, tx_valid}, 0);
    send_smp(2, 14'h0003);
    pop_expect("R8 enabled ch2", exp_word(2, ts_m[2], 14'h0003)); ts_m[2]++;
    send_smp(0, 14'h0004);
    pop_expect("R8 ch0 order", exp_word(0, ts_m[0], 14'h0004)); ts_m[0]++;

    // R9 queue full drops, ts advances
    for (int i = 0; i < 6; i++) send_smp(0, 14'(100 + i));
    for (int i = 0; i < 4; i++) pop_expect("R9 queued", exp_word(0, ts_m[0] + i, 14'(100 + i)));
    chk("R9 drained", {31'b0, tx_valid}, 0);
    ts_m[0] += 6;
    send_smp(0, 14'h3FFF);
    pop_expect("R9 ts after drop", exp_word(0, ts_m[0], 14'h3FFF)); ts_m[0]++;

    // R7 wrap on ch2
    for (int i = 0; i < 300; i++) begin
      send_smp(2, 14'(i));
      pop_expect("R7 wrap", exp_word(2, ts_m[2] % 256, 14'(i)));
      ts_m[2]++;
    end

    // R3 disconnect with go bit also set
    send_smp(0, 14'h0042);
    for (int i = 0; i < 4; i++) send_byte(8'hC0 >> ((3 - i) == 0 ? 0 : 8));
    @(posedge clk); @(negedge clk);
    chk("R3 done pulse", {31'b0, done}, 1);
    chk("R3 stream stopped", {31'b0, tx_valid}, 0);
    @(negedge clk);
    chk("R3 done single", {31'b0, done}, 0);
    send_smp(0, 14'h0043);
    @(negedge clk);
    chk("R4 ignored after stop", {31'b0, tx_valid}, 0);

    // R4 inert word
    send_word(32'h0022_0003);
    send_smp(0, 14'h0044);
    chk("R4 inert word", {31'b0, tx_valid}, 0);
    chk("R4 inert no done", {31'b0, done}, 0);

    // R11 partial word discarded on reset
    send_byte(8'hFF);
    send_byte(8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    start(8'h3C, 8'h80);
    pop_expect("R11 header after reset", 32'h0000_003C);
    send_smp(7, 14'h1234);
    pop_expect("R11 ch7 after reset", exp_word(7, 0, 14'h1234));

    summary();
  end
endmodule